// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block picks which physical frame a memory manager should evict next, using the second-chance (clock) policy. The frames form a ring of `NUM_FRAMES` slots with one hand pointer. Every frame has a reference bit. An access-report pulse naming a frame sets that frame's bit, so the bit records recent use.

When the manager pulses a victim request, the selector starts a sweep that takes one ring position per clock. A frame whose bit is set loses its bit and is passed over, which gives it a second chance. The first frame found with a clear bit becomes the victim. The block returns the victim index with a one-cycle done pulse and moves the hand one slot past the victim. Once the new page is in place, an install strobe sets the victim's bit.

All pins are plain control and status pins and there is no back-pressure. Access reports and install strobes are accepted on every cycle, including during a sweep. A request is acted on only while the block is idle. The reference bits and the hand are driven out so that the frame manager can see the replacement state.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset, all reference bits are 0, the hand is at frame 0, and `busy_o` and `done_o` are both low.
- R2: An access report (`acc_valid_i` high with frame index `acc_frame_i`) sets that frame's bit in `ref_bits_o[acc_frame_i]`, visible on the cycle after the report.
- R3: A request sampled while idle raises `busy_o` on the next cycle. Each following cycle is one sweep step that examines the frame under the hand. If that frame's bit is 1, the step clears the bit and moves the hand forward by one.
- R4: The first frame examined with its bit at 0 is the victim. On the clock edge of that step, `victim_o` takes its index, `done_o` goes high for exactly one cycle and `busy_o` drops. A search of S steps shows `done_o` S+1 cycles after the cycle in which the request was sampled.
- R5: When `done_o` is high, `hand_o` points to the frame after the victim. Frame `NUM_FRAMES-1` wraps to frame 0.
- R6: An install strobe (`inst_i`) sets the bit of the frame currently on `victim_o`, visible on the next cycle.
- R7: If an access report (or install) names a frame in the same cycle that a sweep step clears that frame's bit, the bit stays 1.
- R8: A request that arrives while `busy_o` is high is ignored. It starts no second search and produces no extra `done_o` pulse.
- R9: With no access reports or installs during a search, the search ends within `NUM_FRAMES+1` steps. If every bit is set when the search starts, the victim is the frame the hand started on, after `NUM_FRAMES+1` steps, and all bits end at 0.
- R10: Reference bits are cleared only by sweep steps. While idle, no bit falls and the hand does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | Access report strobe |
| acc_frame_i | input | IDX_W | Frame named by the access report |
| inst_i | input | 1 | Install strobe; sets the bit of the frame on `victim_o` |
| req_i | input | 1 | Victim request pulse; taken only while idle |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse: `victim_o` holds a new victim |
| victim_o | output | IDX_W | Index of the most recently chosen victim |
| hand_o | output | IDX_W | Current hand position |
| ref_bits_o | output | NUM_FRAMES | Reference bit of every frame |

## Verification
The checker enforces several properties on every cycle. Access and install set their bit with priority over a clear. Bits fall only during a sweep, and the hand stays put while idle. Each done pulse lasts one cycle, names the frame that sat under the hand with a clear bit, and leaves the hand one slot past the victim. A search free of access reports stays within the N+1-step bound. Only the directed scenarios can show that particular occupancy patterns produce the expected victim and latency, because the expected result depends on the whole history of accesses. These scenarios cover a clean ring, passing over set frames, a full lap, wrap of the hand, a collision between access and clear, and a request dropped while busy.

// File: rtl/clock_victim_sel_pkg.sv
package clock_victim_sel_pkg;
  typedef enum logic [0:0] {
    SW_IDLE  = 1'b0,
    SW_SWEEP = 1'b1
  } sweep_state_e;
endpackage

// File: rtl/clk_ref_bank.sv
module clk_ref_bank #(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_a_valid,
  input  logic [IDX_W-1:0]      set_a_idx,
  input  logic                  set_b_valid,
  input  logic [IDX_W-1:0]      set_b_idx,
  input  logic                  clr_valid,
  input  logic [IDX_W-1:0]      clr_idx,
  output logic [NUM_FRAMES-1:0] bits
);
  // One flop per frame; a set request always wins over a clear.
  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    logic hit_set, hit_clr;
    assign hit_set = (set_a_valid && (set_a_idx == MY_IDX)) ||
                     (set_b_valid && (set_b_idx == MY_IDX));
    assign hit_clr = clr_valid && (clr_idx == MY_IDX);
    always_ff @(posedge clk) begin
      if (!rst_n)       bits[g] <= 1'b0;
      else if (hit_set) bits[g] <= 1'b1;
      else if (hit_clr) bits[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/clk_hand_ring.sv
module clk_hand_ring #(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] hand
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);
  logic [IDX_W-1:0] hand_nxt;

  // Wrap explicitly so a ring size that is not a power of two works.
  always_comb begin
    if (hand == LAST) hand_nxt = '0;
    else              hand_nxt = hand + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    hand <= '0;
    else if (step) hand <= hand_nxt;
  end
endmodule

// File: rtl/clk_sweep_ctrl.sv
module clk_sweep_ctrl
  import clock_victim_sel_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             cur_bit,
  input  logic [IDX_W-1:0] hand,
  output logic             step,
  output logic             clr_valid,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] victim
);
  sweep_state_e state_q, state_d;
  logic found;

  always_comb begin
    state_d   = state_q;
    step      = 1'b0;
    clr_valid = 1'b0;
    found     = 1'b0;
    unique case (state_q)
      SW_IDLE:  if (req) state_d = SW_SWEEP;
      SW_SWEEP: begin
        step = 1'b1;
        if (cur_bit) begin
          clr_valid = 1'b1;
        end else begin
          found   = 1'b1;
          state_d = SW_IDLE;
        end
      end
      default: state_d = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      done    <= 1'b0;
      victim  <= '0;
    end else begin
      state_q <= state_d;
      done    <= found;
      if (found) victim <= hand;
    end
  end

  assign busy = (state_q == SW_SWEEP);
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid_i,
  input  logic [IDX_W-1:0]      acc_frame_i,
  input  logic                  inst_i,
  input  logic                  req_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [IDX_W-1:0]      victim_o,
  output logic [IDX_W-1:0]      hand_o,
  output logic [NUM_FRAMES-1:0] ref_bits_o
);
  logic             step;
  logic             clr_valid;
  logic             cur_bit;
  logic [IDX_W-1:0] hand;
  logic [IDX_W-1:0] victim;
  logic [NUM_FRAMES-1:0] bits;

  assign cur_bit = bits[hand];

  clk_ref_bank #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_a_valid (acc_valid_i),
    .set_a_idx   (acc_frame_i),
    .set_b_valid (inst_i),
    .set_b_idx   (victim),
    .clr_valid   (clr_valid),
    .clr_idx     (hand),
    .bits        (bits)
  );

  clk_hand_ring #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_hand (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .hand  (hand)
  );

  clk_sweep_ctrl #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req_i),
    .cur_bit   (cur_bit),
    .hand      (hand),
    .step      (step),
    .clr_valid (clr_valid),
    .busy      (busy_o),
    .done      (done_o),
    .victim    (victim)
  );

  assign victim_o   = victim;
  assign hand_o     = hand;
  assign ref_bits_o = bits;
endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  acc_valid_i,
  input logic [IDX_W-1:0]      acc_frame_i,
  input logic                  inst_i,
  input logic                  req_i,
  input logic                  busy_o,
  input logic                  done_o,
  input logic [IDX_W-1:0]      victim_o,
  input logic [IDX_W-1:0]      hand_o,
  input logic [NUM_FRAMES-1:0] ref_bits_o
);
  localparam int CNT_W = $clog2(NUM_FRAMES + 3) + 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

  logic [CNT_W-1:0] steps_q;
  logic             disturbed_q;
  logic [IDX_W-1:0] after_victim;

  assign after_victim = (victim_o == LAST) ? '0 : victim_o + IDX_W'(1);

  // Count sweep steps and note any set request landing during the search.
  always_ff @(posedge clk) begin
    if (!rst_n || !busy_o) begin
      steps_q     <= '0;
      disturbed_q <= 1'b0;
    end else begin
      steps_q     <= steps_q + CNT_W'(1);
      disturbed_q <= disturbed_q | acc_valid_i | inst_i;
    end
  end

  a_r2_access_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid_i) |-> ref_bits_o[$past(acc_frame_i)]);

  a_r3_busy_from_idle_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(req_i) && !$past(done_o)));

  a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r4_victim_was_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(busy_o) && !busy_o && (victim_o == $past(hand_o))
                && !$past(ref_bits_o[hand_o])));

  a_r5_hand_past_victim: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (hand_o == after_victim));

  a_r6_install_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inst_i) |-> ref_bits_o[$past(victim_o)]);

  a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r9_bounded_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !disturbed_q) |-> (steps_q <= CNT_W'(NUM_FRAMES)));

  a_r10_clear_only_sweeping: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ref_bits_o) < $past($countones(ref_bits_o))) |-> $past(busy_o));

  a_r10_hand_still_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy_o) |-> $stable(hand_o));
endmodule

bind clock_victim_sel clock_victim_sel_chk #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid_i (acc_valid_i),
  .acc_frame_i (acc_frame_i),
  .inst_i      (inst_i),
  .req_i       (req_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .victim_o    (victim_o),
  .hand_o      (hand_o),
  .ref_bits_o  (ref_bits_o)
);

// File: tb/clock_victim_sel_test.sv
module clock_victim_sel_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid_i = 1'b0;
  logic [IW-1:0] acc_frame_i = '0;
  logic          inst_i = 1'b0;
  logic          req_i = 1'b0;
  logic          busy_o, done_o;
  logic [IW-1:0] victim_o, hand_o;
  logic [N-1:0]  ref_bits_o;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] mref = '0;
  int mhand = 0;
  int mvictim = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clock_victim_sel #(.NUM_FRAMES(N)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid_i), .acc_frame_i(acc_frame_i),
    .inst_i(inst_i), .req_i(req_i), .busy_o(busy_o), .done_o(done_o),
    .victim_o(victim_o), .hand_o(hand_o), .ref_bits_o(ref_bits_o)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_access(input int f);
    @(negedge clk);
    acc_valid_i = 1'b1;
    acc_frame_i = IW'(f);
    @(negedge clk);
    acc_valid_i = 1'b0;
    mref[f] = 1'b1;
    check("R2", "access sets bit", ref_bits_o[f], 1);
  endtask

  // Model-side prediction of one search from the requirements.
  task automatic predict(output int victim, output int steps);
    steps = 1;
    while (mref[mhand]) begin
      mref[mhand] = 1'b0;
      mhand = (mhand + 1) % N;
      steps++;
    end
    victim = mhand;
    mhand = (mhand + 1) % N;
    mvictim = victim;
  endtask

  task automatic run_request(input string tag, input int exp_victim, input int exp_steps,
                             input int extra_req_at, input int acc_at, input int acc_f);
    int n = 0;
    int seen = -1;
    @(negedge clk);
    req_i = 1'b1;
    while (n < 4 * N && seen < 0) begin
      @(negedge clk);
      n++;
      req_i       = (n == extra_req_at);
      acc_valid_i = (n == acc_at);
      acc_frame_i = IW'(acc_f);
      if (done_o) seen = n;
    end
    req_i = 1'b0;
    acc_valid_i = 1'b0;
    check(tag, "done latency", seen, exp_steps + 1);
    check(tag, "victim", victim_o, exp_victim);
    check("R5", "hand after victim", hand_o, mhand);
    check(tag, "ref bits after search", ref_bits_o, mref);
    check("R4", "busy low at done", busy_o, 0);
    @(negedge clk);
    check("R4", "done single cycle", done_o, 0);
  endtask

  task automatic t_reset;
    check("R1", "bits", ref_bits_o, 0);
    check("R1", "hand", hand_o, 0);
    check("R1", "busy", busy_o, 0);
    check("R1", "done", done_o, 0);
  endtask

  task automatic t_clean_ring;
    int v, s;
    predict(v, s);
    run_request("R4", v, s, -1, -1, 0);
    check("R4", "clean ring picks frame 0", v, 0);
  endtask

  task automatic t_second_chance;
    int v, s;
    do_access(1);
    do_access(2);
    predict(v, s);
    run_request("R3", v, s, -1, -1, 0);
    check("R3", "passed two set frames", s, 3);
  endtask

  task automatic t_install;
    @(negedge clk);
    inst_i = 1'b1;
    @(negedge clk);
    inst_i = 1'b0;
    mref[mvictim] = 1'b1;
    check("R6", "install sets victim bit", ref_bits_o[mvictim], 1);
  endtask

  task automatic t_full_lap;
    int v, s, start;
    start = mhand;
    for (int f = 0; f < N; f++) do_access(f);
    predict(v, s);
    run_request("R9", v, s, -1, -1, 0);
    check("R9", "full lap victim is start", v, start);
    check("R9", "full lap steps", s, N + 1);
  endtask

  task automatic t_wrap;
    int v, s;
    do_access(5);
    do_access(6);
    predict(v, s);
    run_request("R5", v, s, -1, -1, 0);
    check("R5", "victim last frame", v, N - 1);
    check("R5", "hand wrapped", hand_o, 0);
  endtask

  task automatic t_priority;
    int v, s;
    for (int f = 0; f < N; f++) do_access(f);
    predict(v, s);
    mref[(v + 2) % N] = 1'b1;  // R7: access collides with the clearing step
    run_request("R7", v, s, -1, 3, (v + 2) % N);
  endtask

  task automatic t_busy_ignore;
    int v, s;
    int extra = 0;
    do_access(1);
    do_access(3);
    do_access(4);
    predict(v, s);
    run_request("R8", v, s, 2, -1, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done_o || busy_o) extra++;
    end
    check("R8", "no second search", extra, 0);
    check("R8", "hand unchanged", hand_o, mhand);
  endtask

  task automatic t_idle_hold;
    do_access(0);
    repeat (6) @(negedge clk);
    check("R10", "bits held while idle", ref_bits_o, mref);
    check("R10", "hand held while idle", hand_o, mhand);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean_ring();
    t_second_chance();
    t_install();
    t_full_lap();
    t_wrap();
    t_priority();
    t_busy_ignore();
    t_idle_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule